// File: doc/BRIEF.md
# Paired-LUT Logic Cell

This block is one logic cell of a reconfigurable fabric. Six logic inputs feed two small lookup tables. Each table has three inputs and two outputs, so the cell holds four independent 3-input functions and drives four outputs. All outputs are combinational functions of the inputs and of the stored configuration. The cell holds no data registers.

Two mode bits let arithmetic chains pass through the cell without the general routing. The first table can take its third input from a carry arriving from the neighbouring cell. The second table can take its third input from the first table's second output. The second table's second output leaves the cell as the carry toward the next neighbour.

Configuration is loaded through a serial shift chain, one bit per clock while the load enable is high, most significant bit first. A scan output carries the top bit, so several cells can be daisy-chained.

Top module: `clb_paired_lut`

## Requirements
- R1: While reset is low, and on release of reset, every configuration bit is 0. After reset, all four outputs, `carry_o` and `cfg_so_o` read 0 for every input pattern.
- R2: On each rising clock edge with `cfg_en_i` high, bit 0 of the 34-bit configuration word takes `cfg_si_i`, and each other bit takes the value of the bit below it. A word shifted in over 34 enabled edges, most significant bit first, ends up stored unchanged.
- R3: With `cfg_en_i` low, the stored configuration does not change, whatever `cfg_si_i` does.
- R4: `cfg_so_o` always equals configuration bit 33. Shifting a further 34 bits therefore presents the stored word on `cfg_so_o`, most significant bit first.
- R5: Define s1 as `lin_i[2]` when configuration bit 1 is 0, and as `carry_i` when it is 1. With idx1 = {s1, `lin_i[1]`, `lin_i[0]`}, `lout_o[0]` = cfg[2+idx1] and `lout_o[1]` = cfg[10+idx1].
- R6: Define s2 as `lin_i[5]` when configuration bit 0 is 0, and as `lout_o[1]` when it is 1. With idx2 = {s2, `lin_i[4]`, `lin_i[3]`}, `lout_o[2]` = cfg[18+idx2] and `lout_o[3]` = cfg[26+idx2].
- R7: `carry_o` always equals `lout_o[3]`.
- R8: `carry_i` has no effect on any output when configuration bit 1 is 0. `lin_i[5]` has no effect on any output when configuration bit 0 is 1.
- R9: Once configuration is static, the outputs follow input changes within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_si_i | input | 1 | Serial configuration data in |
| cfg_so_o | output | 1 | Serial configuration data out (configuration bit 33) |
| lin_i | input | 6 | Logic inputs; bits 0..2 feed the first table, bits 3..5 feed the second |
| carry_i | input | 1 | Carry from the neighbouring cell |
| lout_o | output | 4 | Logic outputs; bits 0..1 come from the first table, bits 2..3 from the second |
| carry_o | output | 1 | Carry to the next neighbouring cell |

## Verification
A wrong configuration bit stays hidden until an input pattern addresses that table entry. The bench therefore sweeps all 64 input patterns with both carry values after each load, so a bad bit shows on an output in the same cycle it is addressed. A shift fault, such as a dropped, duplicated or misordered bit, is caught in two ways: it changes every later bit's position, which the table sweep exposes, and it shows directly on `cfg_so_o` when the word is shifted back out. A wrong mode bit shows up as an output that depends on the wrong third input, found by toggling `carry_i` and `lin_i[5]` while the other inputs are held.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int LUT_K     = 3;   // inputs per table
  localparam int LUT_M     = 2;   // outputs per table
  localparam int N_LUT     = 2;   // tables per cell (pair structure)
  localparam int MODE_BITS = 2;   // bit0: table1 chain, bit1: table0 carry-in
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int W = 34
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         si_i,
  output logic [W-1:0] cfg_o,
  output logic         so_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (en_i) cfg_q <= {cfg_q[W-2:0], si_i};
  end

  assign cfg_o = cfg_q;
  assign so_o  = cfg_q[W-1];

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cfg_q == '0));

  p_shift_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (so_o == $past(cfg_q[W-2])));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cfg_q));
endmodule

// File: rtl/clb_in_sel.sv
module clb_in_sel #(
  parameter int K = 3
) (
  input  logic [K-1:0] direct_i,
  input  logic         alt_i,
  input  logic         sel_i,
  output logic [K-1:0] idx_o
);
  // only the top table input is steerable
  always_comb begin
    idx_o        = direct_i;
    idx_o[K-1]   = sel_i ? alt_i : direct_i[K-1];
  end
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int K = 3,
  parameter int M = 2,
  localparam int TBL = 1 << K,
  localparam int CW  = M * TBL
) (
  input  logic [CW-1:0] cfg_i,
  input  logic [K-1:0]  idx_i,
  output logic [M-1:0]  out_o
);
  for (genvar j = 0; j < M; j++) begin : g_fn
    logic [TBL-1:0] tbl;
    assign tbl      = cfg_i[j*TBL +: TBL];
    assign out_o[j] = tbl[idx_i];
  end
endmodule

// File: rtl/clb_paired_lut.sv
module clb_paired_lut
  import clb_pkg::*;
#(
  parameter int K = LUT_K,
  parameter int M = LUT_M,
  localparam int N_IN  = N_LUT * K,
  localparam int N_OUT = N_LUT * M,
  localparam int LCW   = M * (1 << K),
  localparam int CFG_W = MODE_BITS + N_LUT * LCW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_si_i,
  output logic             cfg_so_o,
  input  logic [N_IN-1:0]  lin_i,
  input  logic             carry_i,
  output logic [N_OUT-1:0] lout_o,
  output logic             carry_o
);
  logic [CFG_W-1:0] cfg;
  logic [M-1:0]     lut_out [N_LUT];
  logic [N_LUT-1:0] alt_in;

  clb_cfg_chain #(.W(CFG_W)) i_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .si_i  (cfg_si_i),
    .cfg_o (cfg),
    .so_o  (cfg_so_o)
  );

  for (genvar l = 0; l < N_LUT; l++) begin : g_lut
    logic [K-1:0] idx;
    if (l == 0) begin : g_first
      assign alt_in[l] = carry_i;
    end else begin : g_chained
      assign alt_in[l] = lut_out[l-1][M-1];
    end

    // mode bit: table 0 -> bit 1, table 1 -> bit 0
    clb_in_sel #(.K(K)) i_sel (
      .direct_i(lin_i[l*K +: K]),
      .alt_i   (alt_in[l]),
      .sel_i   (cfg[N_LUT-1-l]),
      .idx_o   (idx)
    );

    clb_lut #(.K(K), .M(M)) i_lut (
      .cfg_i(cfg[MODE_BITS + l*LCW +: LCW]),
      .idx_i(idx),
      .out_o(lut_out[l])
    );

    assign lout_o[l*M +: M] = lut_out[l];
  end

  assign carry_o = lut_out[N_LUT-1][M-1];

  p_static_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cfg_en_i) && $stable(lin_i) && $stable(carry_i)) |-> $stable(lout_o));

  p_carry_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cfg_en_i) && $stable(lin_i) && $stable(carry_i)) |-> $stable(carry_o));
endmodule

// File: tb/test_clb_paired_lut.sv
module test_clb_paired_lut;
  localparam int CLK_P = 10;
  localparam int CW    = 34;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_en = 0;
  logic       cfg_si = 0;
  logic       cfg_so;
  logic [5:0] lin = '0;
  logic       cin = 0;
  logic [3:0] lout;
  logic       cout;
  logic [CW-1:0] exp_cfg = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  clb_paired_lut i_clb_paired_lut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_si_i(cfg_si),
    .cfg_so_o(cfg_so), .lin_i(lin), .carry_i(cin), .lout_o(lout), .carry_o(cout)
  );

  function automatic logic [3:0] model(logic [CW-1:0] c, logic [5:0] x, logic ci);
    logic s1, s2, o2;
    logic [2:0] i1, i2;
    logic [3:0] r;
    s1 = c[1] ? ci : x[2];
    i1 = {s1, x[1], x[0]};
    r[0] = c[2 + i1];
    r[1] = c[10 + i1];
    o2 = r[1];
    s2 = c[0] ? o2 : x[5];
    i2 = {s2, x[4], x[3]};
    r[2] = c[18 + i2];
    r[3] = c[26 + i2];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1;
      cfg_si = w[i];
    end
    @(negedge clk);
    cfg_en = 0;
    cfg_si = 0;
    exp_cfg = w;
  endtask

  task automatic sweep(string req);
    int bad = 0;
    for (int v = 0; v < 128; v++) begin
      lin = v[5:0];
      cin = v[6];
      #1;
      if (lout !== model(exp_cfg, lin, cin) || cout !== lout[3]) begin
        bad++;
        if (bad == 1)
          $display("FAIL %s vec=%0h actual=%0h expected=%0h cout=%0b", req, v, lout,
                   model(exp_cfg, lin, cin), cout);
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic t_reset;
    // R1
    rst_n = 0;
    #(CLK_P*2);
    sweep("R1 outputs zero in reset");
    check("R1 scan out in reset", cfg_so, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sweep("R1 outputs zero after reset");
    check("R1 scan out after reset", cfg_so, 0);
  endtask

  task automatic t_pattern(logic [CW-1:0] w, string tag);
    // R2 R5 R6 R7
    load(w);
    check({tag, " R4 top bit after load"}, cfg_so, w[CW-1]);
    sweep({tag, " R5 R6 R7 table sweep"});
  endtask

  task automatic t_adder;
    // both tables as full adders chained through the cell: R5 R6 R8
    logic [1:0] s0;
    logic [1:0] s1v;
    int bad = 0;
    load({8'hE8, 8'h96, 8'hE8, 8'h96, 2'b11});
    for (int v = 0; v < 128; v++) begin
      lin = v[5:0];
      cin = v[6];
      #1;
      s0  = lin[0] + lin[1] + cin;
      s1v = lin[3] + lin[4] + s0[1];
      if (lout !== {s1v, s0} || cout !== s1v[1]) begin
        bad++;
        if (bad == 1)
          $display("FAIL R5 R6 adder vec=%0h actual=%0h expected=%0h", v, lout, {s1v, s0});
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic t_ignore;
    // R8: carry_i ignored with bit1=0; lin[5] ignored with bit0=1
    logic [3:0] ref_o;
    load({8'hE8, 8'h96, 8'h5A, 8'hC3, 2'b01});
    lin = 6'b001011; cin = 0; #1; ref_o = lout;
    cin = 1; #1;
    check("R8 carry_i ignored", lout, ref_o);
    lin[5] = 1; #1;
    check("R8 lin5 ignored", lout, ref_o);
    check("R8 model", lout, model(exp_cfg, lin, cin));
  endtask

  task automatic t_hold;
    // R3: toggling serial input without enable leaves configuration unchanged
    logic [CW-1:0] w = 34'h2_DEAD_BEEF;
    load(w);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_si = ~cfg_si;
    end
    cfg_si = 0;
    check("R3 scan out held", cfg_so, w[CW-1]);
    sweep("R3 tables held");
  endtask

  task automatic t_scan;
    // R4: shift the word back out, MSB first
    logic [CW-1:0] w = 34'h1_3579_BDF1;
    logic [CW-1:0] got = '0;
    load(w);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      #1;
      got[i] = cfg_so;
      cfg_en = 1;
      cfg_si = 0;
    end
    @(negedge clk);
    cfg_en = 0;
    exp_cfg = '0;
    check("R4 scan out word", got, w[31:0]);
    check("R4 scan out top bits", {30'd0, got[33:32]}, {30'd0, w[33:32]});
    sweep("R2 chain empty after unload");
  endtask

  task automatic t_comb;
    // R9: outputs track inputs with the clock parked
    load({8'h80, 8'h01, 8'hFE, 8'h7F, 2'b00});
    lin = 6'b000000; cin = 0; #1;
    check("R9 comb a", lout, model(exp_cfg, lin, cin));
    lin = 6'b111111; #1;
    check("R9 comb b", lout, model(exp_cfg, lin, cin));
    check("R7 carry out", cout, lout[3]);
  endtask

  initial begin
    t_reset();
    t_pattern(34'h3_FFFF_FFFF, "ones");
    t_pattern(34'h2_A5C3_691E, "mixA");
    t_pattern(34'h1_0F1E_2D3E, "mixB");
    t_pattern(34'h0_1234_5678, "mixC");
    t_adder();
    t_ignore();
    t_hold();
    t_scan();
    t_comb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule